// File: doc/BRIEF.md
# USB OUT Transaction Status Register

This block holds the read-only status byte that a microcontroller reads after each OUT or SETUP transaction of a low-speed USB function with three endpoints (EP0, EP1, EP2). Upstream logic decodes the packets and hands over single-cycle token events together with the endpoint number, the data PID parity and the number of bytes received. The block records the endpoint that owns the current OUT data, the data toggle, a setup marker and the byte count, and packs them into one byte.

A SETUP arrival has side effects beyond the status byte. It flushes every IN FIFO with a one-cycle strobe, and when the setup marker goes from clear to set it pulses a clear to both EP0 stall flags. The handshake choice for the current token is also produced here: SETUP is always acknowledged, while OUT may be answered with NAK or STALL. When neither EP1 OUT nor EP2 OUT is enabled, the endpoint field carries a fixed revision code instead.

Top module: `usb_out_status`

## Requirements
- R1: After reset the status byte is 0x00 while EP1 or EP2 OUT is enabled, and err_ovf, flush_in and stall_clr are 0.
- R2: Bits 7-6 of status hold the endpoint of the last accepted token: ep_num (00 EP0, 01 EP1, 10 EP2) for OUT, and 00 for SETUP. This holds while ep1_out_en or ep2_out_en is 1.
- R3: While ep1_out_en and ep2_out_en are both 0, bits 7-6 show the parameter REV (default 2'b11) and the stored endpoint is not shown.
- R4: Bit 5 takes data_pid_odd (1 = DATA1, 0 = DATA0) on every accepted SETUP or OUT token and holds otherwise.
- R5: Bit 4 (setup marker) is set by setup_tok and cleared by rd_done. When both arrive in one cycle, setup_tok wins. An OUT token leaves it unchanged.
- R6: Bits 3-0 take min(rx_count, MAX_BYTES) (MAX_BYTES default 8) on each accepted token. A count of 0 marks a zero-length packet.
- R7: err_ovf becomes 1 when an accepted token carries rx_count above MAX_BYTES, and stays 1 until reset.
- R8: flush_in is high for exactly the one cycle after each cycle with setup_tok.
- R9: stall_clr is high for exactly one cycle after the setup marker rises from 0 to 1. A SETUP that finds the marker already set gives no pulse.
- R10: hs_valid is 1 in the cycle of an accepted token. hs_code is 00 ACK for SETUP whatever ep_stall and ep_busy are. For OUT it is 10 STALL if ep_stall is set, else 01 NAK if ep_busy is set, else 00 ACK.
- R11: When setup_tok and out_tok coincide, the token is treated as SETUP: endpoint 00, marker set, ACK.
- R12: An OUT token with ep_num = 11 is ignored: hs_valid stays 0 and the status byte and err_ovf do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_tok | input | 1 | One-cycle event: valid EP0 SETUP token with its data |
| out_tok | input | 1 | One-cycle event: OUT token with its data |
| ep_num | input | 2 | Endpoint addressed by out_tok |
| data_pid_odd | input | 1 | 1 when the data PID was DATA1 |
| rx_count | input | CNT_W | Bytes received in the data packet |
| rd_done | input | 1 | One-cycle strobe: microcontroller finished reading the OUT data |
| ep1_out_en | input | 1 | EP1 OUT enabled |
| ep2_out_en | input | 1 | EP2 OUT enabled |
| ep_stall | input | 1 | Addressed endpoint is stalled |
| ep_busy | input | 1 | Addressed endpoint cannot take data |
| status | output | 8 | Packed status byte |
| flush_in | output | 1 | One-cycle strobe that empties all IN FIFOs |
| stall_clr | output | 1 | One-cycle clear of both EP0 stall flags |
| hs_valid | output | 1 | Handshake decision valid for the current token |
| hs_code | output | 2 | Handshake: 00 ACK, 01 NAK, 10 STALL |
| err_ovf | output | 1 | Sticky flag: a count above MAX_BYTES was clamped |

## Verification
The assertions check on every cycle that a SETUP is always acknowledged and is followed by a flush strobe. They also check that the stall clear lines up with a rise of the setup marker, that the count field never exceeds the limit, that the overflow flag never drops, and that the toggle follows the PID of each accepted token. Only the bench scenarios show the full field values for every endpoint, parity and count. The same holds for the revision code under each enable combination, the ignoring of endpoint 3, the priority of SETUP over a coinciding OUT or read-done, and the absence of a stall clear on a repeated SETUP.

// File: rtl/usb_out_status_pkg.sv
package usb_out_status_pkg;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_e;

  // Saturate a received byte count to the field limit.
  function automatic logic [3:0] clamp_cnt(input logic [7:0] raw, input logic [3:0] lim);
    return (raw > {4'b0000, lim}) ? lim : raw[3:0];
  endfunction

  // Handshake for a non-SETUP token: stall beats busy beats accept.
  function automatic hs_e out_handshake(input logic stalled, input logic busy);
    if (stalled)   return HS_STALL;
    else if (busy) return HS_NAK;
    else           return HS_ACK;
  endfunction

endpackage

// File: rtl/ost_capture.sv
module ost_capture
  import usb_out_status_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_en,
  input  logic       cap_setup,
  input  logic [1:0] ep_num,
  input  logic       pid_odd,
  input  logic [7:0] raw_cnt,
  output logic [1:0] ep_q,
  output logic       tog_q,
  output logic [3:0] cnt_q,
  output logic       ovf_q,
  output logic       ovf_evt
);
  localparam logic [3:0] LIM = 4'(MAX_BYTES);

  assign ovf_evt = cap_en && (raw_cnt > {4'b0000, LIM});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_q  <= 2'b00;
      tog_q <= 1'b0;
      cnt_q <= 4'd0;
      ovf_q <= 1'b0;
    end else begin
      if (cap_en) begin
        ep_q  <= cap_setup ? 2'b00 : ep_num;
        tog_q <= pid_odd;
        cnt_q <= clamp_cnt(raw_cnt, LIM);
      end
      if (ovf_evt) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ost_setup_ctl.sv
module ost_setup_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic setup_evt,
  input  logic rd_done,
  output logic flag_q,
  output logic flush_q,
  output logic stall_clr
);
  logic flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      flag_d  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (setup_evt)    flag_q <= 1'b1;
      else if (rd_done) flag_q <= 1'b0;
      flag_d  <= flag_q;
      flush_q <= setup_evt;
    end
  end

  assign stall_clr = flag_q & ~flag_d;
endmodule

// File: rtl/ost_hs_arb.sv
module ost_hs_arb
  import usb_out_status_pkg::*;
(
  input  logic       setup_evt,
  input  logic       out_evt,
  input  logic       ep_stall,
  input  logic       ep_busy,
  output logic       hs_valid,
  output logic [1:0] hs_code
);
  hs_e sel;

  always_comb begin
    if (setup_evt) sel = HS_ACK;
    else           sel = out_handshake(ep_stall, ep_busy);
  end

  assign hs_valid = setup_evt | out_evt;
  assign hs_code  = sel;
endmodule

// File: rtl/usb_out_status.sv
module usb_out_status
  import usb_out_status_pkg::*;
#(
  parameter int         CNT_W     = 4,
  parameter int         MAX_BYTES = 8,
  parameter logic [1:0] REV       = 2'b11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_tok,
  input  logic             out_tok,
  input  logic [1:0]       ep_num,
  input  logic             data_pid_odd,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rd_done,
  input  logic             ep1_out_en,
  input  logic             ep2_out_en,
  input  logic             ep_stall,
  input  logic             ep_busy,
  output logic [7:0]       status,
  output logic             flush_in,
  output logic             stall_clr,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             err_ovf
);
  localparam logic [1:0] EP_NONE = 2'b11;

  // Named internal events for the checker.
  logic       setup_evt;
  logic       out_evt;
  logic       cap_evt;
  logic       ovf_evt;
  logic [1:0] ep_q;
  logic       tog_q;
  logic [3:0] cnt_q;
  logic       flag_q;
  logic       show_ep;

  assign setup_evt = setup_tok;
  assign out_evt   = out_tok && (ep_num != EP_NONE) && !setup_tok;
  assign cap_evt   = setup_evt | out_evt;
  assign show_ep   = ep1_out_en | ep2_out_en;

  ost_capture #(.MAX_BYTES(MAX_BYTES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_evt),
    .cap_setup(setup_evt),
    .ep_num   (ep_num),
    .pid_odd  (data_pid_odd),
    .raw_cnt  (8'(rx_count)),
    .ep_q     (ep_q),
    .tog_q    (tog_q),
    .cnt_q    (cnt_q),
    .ovf_q    (err_ovf),
    .ovf_evt  (ovf_evt)
  );

  ost_setup_ctl u_setup (
    .clk      (clk),
    .rst_n    (rst_n),
    .setup_evt(setup_evt),
    .rd_done  (rd_done),
    .flag_q   (flag_q),
    .flush_q  (flush_in),
    .stall_clr(stall_clr)
  );

  ost_hs_arb u_hs (
    .setup_evt(setup_evt),
    .out_evt  (out_evt),
    .ep_stall (ep_stall),
    .ep_busy  (ep_busy),
    .hs_valid (hs_valid),
    .hs_code  (hs_code)
  );

  assign status = {(show_ep ? ep_q : REV), tog_q, flag_q, cnt_q};
endmodule

// File: rtl/usb_out_status_chk.sv
module usb_out_status_chk #(
  parameter int MAX_BYTES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       setup_tok,
  input logic       rd_done,
  input logic       data_pid_odd,
  input logic       cap_evt,
  input logic [7:0] status,
  input logic       flush_in,
  input logic       stall_clr,
  input logic       hs_valid,
  input logic [1:0] hs_code,
  input logic       err_ovf
);
  // R10
  setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_tok |-> (hs_valid && hs_code == 2'b00));

  // R8
  flush_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_tok |=> flush_in);

  // R8
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_in && !setup_tok) |=> !flush_in);

  // R9
  stall_clr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_clr |-> $rose(status[4]));

  // R9
  rise_gives_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> stall_clr);

  // R5
  setup_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_tok |=> status[4]);

  // R5
  rd_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !setup_tok) |=> !status[4]);

  // R6
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:0] <= 4'(MAX_BYTES));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |=> err_ovf);

  // R4
  toggle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (status[5] == $past(data_pid_odd)));
endmodule

bind usb_out_status usb_out_status_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .setup_tok   (setup_tok),
  .rd_done     (rd_done),
  .data_pid_odd(data_pid_odd),
  .cap_evt     (cap_evt),
  .status      (status),
  .flush_in    (flush_in),
  .stall_clr   (stall_clr),
  .hs_valid    (hs_valid),
  .hs_code     (hs_code),
  .err_ovf     (err_ovf)
);

// File: tb/usb_out_status_tb.sv
module usb_out_status_tb;
  localparam int CNT_W = 4;
  localparam int LIM   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_tok = 0, out_tok = 0, data_pid_odd = 0, rd_done = 0;
  logic [1:0] ep_num = 0;
  logic [CNT_W-1:0] rx_count = 0;
  logic ep1_out_en = 1, ep2_out_en = 0, ep_stall = 0, ep_busy = 0;
  logic [7:0] status;
  logic flush_in, stall_clr, hs_valid, err_ovf;
  logic [1:0] hs_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model
  logic [1:0] m_ep = 0;
  logic m_tog = 0, m_flag = 0, m_ovf = 0;
  logic [3:0] m_cnt = 0;

  always #4 clk = ~clk;

  usb_out_status u_dut (
    .clk(clk), .rst_n(rst_n), .setup_tok(setup_tok), .out_tok(out_tok),
    .ep_num(ep_num), .data_pid_odd(data_pid_odd), .rx_count(rx_count),
    .rd_done(rd_done), .ep1_out_en(ep1_out_en), .ep2_out_en(ep2_out_en),
    .ep_stall(ep_stall), .ep_busy(ep_busy), .status(status),
    .flush_in(flush_in), .stall_clr(stall_clr), .hs_valid(hs_valid),
    .hs_code(hs_code), .err_ovf(err_ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_status();
    return {m_ep, m_tog, m_flag, m_cnt};
  endfunction

  // One transaction; starts and ends just after a falling edge.
  task automatic cyc(input logic s, input logic o, input logic [1:0] ep,
                     input logic pid, input logic [3:0] cnt,
                     input logic stl, input logic bsy, input logic rd);
    logic acc_out, acc, flag_before;
    int exp_code;
    setup_tok = s; out_tok = o; ep_num = ep; data_pid_odd = pid;
    rx_count = cnt; ep_stall = stl; ep_busy = bsy; rd_done = rd;
    acc_out = o && (ep != 2'd3) && !s;
    acc = s || acc_out;
    #1;
    check("R10/R12 hs_valid", int'(hs_valid), int'(acc));
    if (acc) begin
      exp_code = s ? 0 : (stl ? 2 : (bsy ? 1 : 0));
      check(s ? "R10/R11 setup ack" : "R10 out handshake", int'(hs_code), exp_code);
    end
    flag_before = m_flag;
    if (acc) begin
      m_ep  = s ? 2'd0 : ep;
      m_tog = pid;
      m_cnt = (int'(cnt) > LIM) ? 4'(LIM) : cnt;
      if (int'(cnt) > LIM) m_ovf = 1'b1;
    end
    if (s) m_flag = 1'b1;
    else if (rd) m_flag = 1'b0;
    @(negedge clk);
    setup_tok = 0; out_tok = 0; rd_done = 0;
    check("R2/R4/R5/R6 status", int'(status), exp_status());
    check("R7 err_ovf", int'(err_ovf), int'(m_ovf));
    check("R8 flush_in", int'(flush_in), int'(s));
    check("R9 stall_clr", int'(stall_clr), int'(s && !flag_before));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", int'(status), 0);
    check("R1 err_ovf", int'(err_ovf), 0);
    check("R1 flush_in", int'(flush_in), 0);
    check("R1 stall_clr", int'(stall_clr), 0);
    ep1_out_en = 0; #1;
    check("R3 revision at reset", int'(status[7:6]), 3);
    ep1_out_en = 1;
    @(negedge clk);

    // R2 R4 R6 R7 R10 R12: OUT sweep over endpoint, parity and count
    for (int e = 0; e < 4; e++)
      for (int p = 0; p < 2; p++)
        for (int c = 0; c < 16; c++)
          cyc(1'b0, 1'b1, 2'(e), 1'(p), 4'(c), c[0], c[1], 1'b0);

    // R12: ignored endpoint after a known state
    cyc(1'b0, 1'b1, 2'd2, 1'b0, 4'd5, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 2'd3, 1'b1, 4'd7, 1'b0, 1'b0, 1'b0);

    // R3: endpoint field versus enables
    for (int en = 0; en < 4; en++) begin
      ep1_out_en = en[0]; ep2_out_en = en[1]; #1;
      check("R3 endpoint/revision", int'(status[7:6]), (en == 0) ? 3 : int'(m_ep));
      @(negedge clk);
    end
    ep1_out_en = 1; ep2_out_en = 0;

    // R5 R8 R9 R10: SETUP with stall and busy set
    cyc(1'b1, 1'b0, 2'd1, 1'b1, 4'd8, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
    // R9: repeated SETUP while marker set gives no stall clear
    cyc(1'b1, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
    // R5: OUT keeps marker
    cyc(1'b0, 1'b1, 2'd1, 1'b1, 4'd3, 1'b0, 1'b0, 1'b0);
    // R5: read done clears
    cyc(1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1);
    // R5: setup wins over simultaneous read done
    cyc(1'b1, 1'b0, 2'd0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1);
    // R11: SETUP and OUT together on EP2
    cyc(1'b1, 1'b1, 2'd2, 1'b0, 4'd12, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule